// File: doc/BRIEF.md
# Serial Flash Program and Erase Sequencer

This block turns a single erase or write request into the sequence of serial-flash commands a command engine must issue. For a write it takes a start address, a byte count and a byte stream. It cuts the write into program operations of no more than four bytes, and no operation runs past the end of a 256-byte page. Each program or erase is preceded by a write-enable command. After each one, the block reads the flash status byte again and again until the write-in-progress flag clears.

The command engine sees a one-cycle `cmd_req` pulse carrying opcode, address, transmit count, receive count and transmit data. It answers with a `cmd_done` pulse and the received bytes. The device size comes from a signature input. A request that would run past the end of the device is refused without any command. Only one request runs at a time. The outcome is reported with `op_done`, `op_error` and a byte count.

States and transitions. `S_IDLE` accepts a request and goes to:
- `S_FINISH` on a refusal or on a zero-length write;
- `S_WREN_REQ` for an erase;
- `S_GATHER` for a write.

`S_GATHER` collects the bytes of one chunk and goes to `S_WREN_REQ` on the last byte. The block then steps through `S_WREN_REQ` → `S_WREN_WAIT` → `S_OP_REQ` → `S_OP_WAIT` → `S_POLL_REQ` → `S_POLL_WAIT`. Each `*_WAIT` state holds until `cmd_done`. From `S_POLL_WAIT`:
- if the status flag is still set, the block returns to `S_POLL_REQ`;
- otherwise it goes to `S_FINISH` (erase, or last chunk) or to `S_GATHER` (next chunk).

`S_FINISH` lasts one cycle and returns to `S_IDLE`.

Top module: `flash_pgm_seq`

## Requirements
- R1: `req_ready` is high only in the idle state. A `req_valid` pulse while the block is busy is ignored: it causes no command and no extra `op_done`. After reset, `req_ready` is 1 and `cmd_req`, `wr_ready`, `op_done` and `bytes_written` are 0.
- R2: The signature `dev_sig` selects the device size: 0x13 → 1 MB, 0x14 → 2 MB, 0x15 → 4 MB, 0x16 → 8 MB, 0x17 → 16 MB. Any other value leaves no valid device. A request is refused if the signature is invalid or if `req_addr + req_len` exceeds the size. A refused request issues no command and raises `op_done` together with `op_error`.
- R3: A write is split into chunks. Each chunk is min(remaining, 4, 256 − (address mod 256)) bytes, so no chunk crosses a 256-byte page.
- R4: Every program or erase command is immediately preceded by a write-enable command: opcode 0x06, transmit count 1, receive count 0, address 0.
- R5: A program command has opcode 0x02, the chunk address, transmit count = chunk length + 4 and receive count 0. Its `cmd_tx_data` holds the first chunk byte in bits 7:0, the next byte in bits 15:8, and so on. Unused bytes are zero.
- R6: An erase is one command: opcode 0xD8, address `req_addr`, transmit count 4, receive count 0. For an erase, `req_len` is used only in the range check of R2.
- R7: After each program or erase, the block issues status reads (opcode 0x05, transmit 1, receive 1, address 0). It keeps issuing them while `cmd_rx_data` bit 0 reads 1 and moves on only after it reads 0.
- R8: A valid write with `req_len` = 0 finishes with `op_done`, no `op_error`, no command and `bytes_written` = 0.
- R9: When `op_done` is high, `bytes_written` holds the bytes programmed by that request: `req_len` for a write, 0 for an erase or a refusal.
- R10: `cmd_req` is a one-cycle pulse. No new command is issued before the `cmd_done` of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_sig | input | 8 | Device signature selecting the flash size |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_erase | input | 1 | 1 = sector erase, 0 = write |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W+1 | Byte count |
| req_ready | output | 1 | Idle, ready for a request |
| wr_valid | input | 1 | Write byte available |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Byte taken when `wr_valid` is also high |
| cmd_req | output | 1 | Command issue pulse |
| cmd_opcode | output | 8 | Command opcode |
| cmd_addr | output | ADDR_W | Command address |
| cmd_tx_cnt | output | clog2(CHUNK_MAX+5) | Bytes to transmit, including opcode and address |
| cmd_rx_cnt | output | clog2(CHUNK_MAX+5) | Bytes to receive |
| cmd_tx_data | output | 8*CHUNK_MAX | Program data, first byte least significant |
| cmd_rx_data | input | 8*CHUNK_MAX | Received bytes, valid with `cmd_done` |
| cmd_done | input | 1 | Command finished |
| op_done | output | 1 | Request finished (one cycle) |
| op_error | output | 1 | Request refused (with `op_done`) |
| bytes_written | output | ADDR_W+1 | Bytes programmed by the last request |

## Verification
The bench builds the block with its default parameters: 24-bit addresses, 256-byte pages, 4-byte chunks and signatures 0x13 to 0x17. These defaults make three things reachable:
- writes that start two bytes before a page end;
- a 1 MB device whose last bytes can be hit exactly or overrun by one;
- the 16 MB device, whose top address wraps the 24-bit chunk address.

A command-engine model holds the status flag busy for a chosen number of reads, so poll loops of zero to three extra reads are covered.

// File: rtl/fps_pkg.sv
package fps_pkg;

    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_PROG   = 8'h02;
    localparam logic [7:0] OPC_ERASE  = 8'hD8;
    localparam logic [7:0] OPC_STATUS = 8'h05;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GATHER,
        S_WREN_REQ,
        S_WREN_WAIT,
        S_OP_REQ,
        S_OP_WAIT,
        S_POLL_REQ,
        S_POLL_WAIT,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/fps_range_check.sv
module fps_range_check #(
    parameter int         ADDR_W        = 24,
    parameter logic [7:0] SIG_BASE      = 8'h13,
    parameter int         NUM_SIZES     = 5,
    parameter int         MIN_SIZE_LOG2 = 20
) (
    input  logic [7:0]        sig,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W:0]   len,
    output logic              reject
);
    localparam int LEN_W = ADDR_W + 1;

    logic [7:0]     sig_idx;
    logic [LEN_W-1:0] limit;
    logic           sig_ok;
    logic [LEN_W:0] span_end;

    assign sig_idx  = sig - SIG_BASE;
    assign span_end = {2'b00, addr} + {1'b0, len};

    always_comb begin
        limit  = '0;
        sig_ok = 1'b0;
        for (int k = 0; k < NUM_SIZES; k++) begin
            if (sig_idx == 8'(k)) begin
                limit  = LEN_W'(1) << (MIN_SIZE_LOG2 + k);
                sig_ok = 1'b1;
            end
        end
    end

    assign reject = !sig_ok || (span_end > {1'b0, limit});

endmodule

// File: rtl/fps_chunk_calc.sv
module fps_chunk_calc #(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 256,
    parameter int CHUNK_MAX  = 4
) (
    input  logic [$clog2(PAGE_BYTES)-1:0]  page_off,
    input  logic [ADDR_W:0]                remaining,
    output logic [$clog2(CHUNK_MAX+1)-1:0] chunk_len
);
    localparam int LEN_W = ADDR_W + 1;
    localparam int CNT_W = $clog2(CHUNK_MAX + 1);

    logic [LEN_W-1:0] room;
    logic [LEN_W-1:0] pick;

    assign room = LEN_W'(PAGE_BYTES) - LEN_W'(page_off);

    always_comb begin
        pick = remaining;
        if (pick > LEN_W'(CHUNK_MAX)) pick = LEN_W'(CHUNK_MAX);
        if (pick > room)              pick = room;
    end

    assign chunk_len = CNT_W'(pick);

endmodule

// File: rtl/fps_byte_packer.sv
module fps_byte_packer #(
    parameter int CHUNK_MAX = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           push,
    input  logic [7:0]                     din,
    output logic [$clog2(CHUNK_MAX+1)-1:0] count,
    output logic [8*CHUNK_MAX-1:0]         word
);
    localparam int CNT_W = $clog2(CHUNK_MAX + 1);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
            word  <= '0;
        end else if (push) begin
            for (int i = 0; i < CHUNK_MAX; i++) begin
                if (count == CNT_W'(i)) word[i*8 +: 8] <= din;
            end
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
    import fps_pkg::*;
#(
    parameter int         ADDR_W        = 24,
    parameter int         PAGE_BYTES    = 256,
    parameter int         CHUNK_MAX     = 4,
    parameter logic [7:0] SIG_BASE      = 8'h13,
    parameter int         NUM_SIZES     = 5,
    parameter int         MIN_SIZE_LOG2 = 20
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [7:0]                      dev_sig,
    input  logic                            req_valid,
    input  logic                            req_erase,
    input  logic [ADDR_W-1:0]               req_addr,
    input  logic [ADDR_W:0]                 req_len,
    output logic                            req_ready,
    input  logic                            wr_valid,
    input  logic [7:0]                      wr_data,
    output logic                            wr_ready,
    output logic                            cmd_req,
    output logic [7:0]                      cmd_opcode,
    output logic [ADDR_W-1:0]               cmd_addr,
    output logic [$clog2(CHUNK_MAX+5)-1:0]  cmd_tx_cnt,
    output logic [$clog2(CHUNK_MAX+5)-1:0]  cmd_rx_cnt,
    output logic [8*CHUNK_MAX-1:0]          cmd_tx_data,
    input  logic [8*CHUNK_MAX-1:0]          cmd_rx_data,
    input  logic                            cmd_done,
    output logic                            op_done,
    output logic                            op_error,
    output logic [ADDR_W:0]                 bytes_written
);
    localparam int LEN_W     = ADDR_W + 1;
    localparam int CNT_W     = $clog2(CHUNK_MAX + 1);
    localparam int TXC_W     = $clog2(CHUNK_MAX + 5);
    localparam int DATA_W    = 8 * CHUNK_MAX;
    localparam int PAGE_LOG2 = $clog2(PAGE_BYTES);

    seq_state_e state_q, state_d;

    logic              erase_q;
    logic              err_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic [LEN_W-1:0]  written_q;

    logic              reject;
    logic [CNT_W-1:0]  chunk_len;
    logic [CNT_W-1:0]  pk_count;
    logic [DATA_W-1:0] pk_word;
    logic              pk_clr;
    logic              pk_push;
    logic              last_byte;
    logic              wip;
    logic              chunk_step;
    logic              unused_rx;

    assign wip       = cmd_rx_data[0];
    assign unused_rx = ^cmd_rx_data[DATA_W-1:1];

    fps_range_check #(
        .ADDR_W(ADDR_W), .SIG_BASE(SIG_BASE),
        .NUM_SIZES(NUM_SIZES), .MIN_SIZE_LOG2(MIN_SIZE_LOG2)
    ) u_range (
        .sig(dev_sig), .addr(req_addr), .len(req_len), .reject(reject)
    );

    fps_chunk_calc #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .CHUNK_MAX(CHUNK_MAX)
    ) u_chunk (
        .page_off(cur_addr_q[PAGE_LOG2-1:0]), .remaining(remain_q),
        .chunk_len(chunk_len)
    );

    assign pk_clr  = (state_q == S_IDLE) || (state_q == S_POLL_WAIT);
    assign pk_push = (state_q == S_GATHER) && wr_valid;

    fps_byte_packer #(.CHUNK_MAX(CHUNK_MAX)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(pk_clr), .push(pk_push),
        .din(wr_data), .count(pk_count), .word(pk_word)
    );

    assign last_byte  = (pk_count + CNT_W'(1)) == chunk_len;
    assign chunk_step = (state_q == S_POLL_WAIT) && cmd_done && !wip && !erase_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (reject)                    state_d = S_FINISH;
                    else if (req_erase)            state_d = S_WREN_REQ;
                    else if (req_len == '0)        state_d = S_FINISH;
                    else                           state_d = S_GATHER;
                end
            end
            S_GATHER:    if (wr_valid && last_byte) state_d = S_WREN_REQ;
            S_WREN_REQ:  state_d = S_WREN_WAIT;
            S_WREN_WAIT: if (cmd_done) state_d = S_OP_REQ;
            S_OP_REQ:    state_d = S_OP_WAIT;
            S_OP_WAIT:   if (cmd_done) state_d = S_POLL_REQ;
            S_POLL_REQ:  state_d = S_POLL_WAIT;
            S_POLL_WAIT: begin
                if (cmd_done) begin
                    if (wip)
                        state_d = S_POLL_REQ;
                    else if (erase_q || remain_q == LEN_W'(chunk_len))
                        state_d = S_FINISH;
                    else
                        state_d = S_GATHER;
                end
            end
            S_FINISH:    state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // Request datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_q    <= 1'b0;
            err_q      <= 1'b0;
            cur_addr_q <= '0;
            remain_q   <= '0;
            written_q  <= '0;
        end else if (state_q == S_IDLE && req_valid) begin
            erase_q    <= req_erase;
            err_q      <= reject;
            cur_addr_q <= req_addr;
            remain_q   <= req_len;
            written_q  <= '0;
        end else if (chunk_step) begin
            cur_addr_q <= cur_addr_q + ADDR_W'(chunk_len);
            remain_q   <= remain_q - LEN_W'(chunk_len);
            written_q  <= written_q + LEN_W'(chunk_len);
        end
    end

    // Outputs
    always_comb begin
        req_ready   = (state_q == S_IDLE);
        wr_ready    = (state_q == S_GATHER);
        op_done     = (state_q == S_FINISH);
        op_error    = (state_q == S_FINISH) && err_q;
        cmd_req     = 1'b0;
        cmd_opcode  = '0;
        cmd_addr    = '0;
        cmd_tx_cnt  = '0;
        cmd_rx_cnt  = '0;
        cmd_tx_data = '0;
        unique case (state_q)
            S_WREN_REQ: begin
                cmd_req    = 1'b1;
                cmd_opcode = OPC_WREN;
                cmd_tx_cnt = TXC_W'(1);
            end
            S_OP_REQ: begin
                cmd_req  = 1'b1;
                cmd_addr = cur_addr_q;
                if (erase_q) begin
                    cmd_opcode = OPC_ERASE;
                    cmd_tx_cnt = TXC_W'(4);
                end else begin
                    cmd_opcode  = OPC_PROG;
                    cmd_tx_cnt  = TXC_W'(chunk_len) + TXC_W'(4);
                    cmd_tx_data = pk_word;
                end
            end
            S_POLL_REQ: begin
                cmd_req    = 1'b1;
                cmd_opcode = OPC_STATUS;
                cmd_tx_cnt = TXC_W'(1);
                cmd_rx_cnt = TXC_W'(1);
            end
            default: ;
        endcase
    end

    assign bytes_written = written_q;

    // Checks that watch the command stream
    logic [7:0] last_op_q;
    logic       waiting_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_op_q <= '0;
            waiting_q <= 1'b0;
        end else begin
            if (cmd_req) last_op_q <= cmd_opcode;
            if (cmd_req)       waiting_q <= 1'b1;
            else if (cmd_done) waiting_q <= 1'b0;
        end
    end

    assert_busy_no_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |-> !req_ready);

    assert_err_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_error |-> op_done);

    assert_page_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_opcode == OPC_PROG) |->
        ((cmd_tx_cnt > TXC_W'(4)) && (cmd_tx_cnt <= TXC_W'(CHUNK_MAX + 4)) &&
         ({1'b0, cmd_addr[PAGE_LOG2-1:0]} + (PAGE_LOG2+1)'(cmd_tx_cnt - TXC_W'(4))
          <= (PAGE_LOG2+1)'(PAGE_BYTES))));

    assert_wren_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && (cmd_opcode == OPC_PROG || cmd_opcode == OPC_ERASE)) |->
        (last_op_q == OPC_WREN));

    assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |=> !cmd_req);

    assert_wait_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting_q && !cmd_done) |-> !cmd_req);

endmodule

// File: tb/flash_pgm_seq_bench.sv
`timescale 1ns/100ps
module flash_pgm_seq_bench;

    typedef struct packed {
        logic [7:0]  op;
        logic [23:0] addr;
        logic [3:0]  tx;
        logic [3:0]  rx;
        logic [31:0] data;
    } cmd_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  dev_sig = 8'h13;
    logic        req_valid = 0;
    logic        req_erase = 0;
    logic [23:0] req_addr = '0;
    logic [24:0] req_len = '0;
    logic        req_ready;
    logic        wr_valid = 0;
    logic [7:0]  wr_data = '0;
    logic        wr_ready;
    logic        cmd_req;
    logic [7:0]  cmd_opcode;
    logic [23:0] cmd_addr;
    logic [3:0]  cmd_tx_cnt;
    logic [3:0]  cmd_rx_cnt;
    logic [31:0] cmd_tx_data;
    logic [31:0] cmd_rx_data = '0;
    logic        cmd_done = 0;
    logic        op_done;
    logic        op_error;
    logic [24:0] bytes_written;

    always #2.5 clk = ~clk;

    flash_pgm_seq u_flash_pgm_seq (
        .clk(clk), .rst_n(rst_n), .dev_sig(dev_sig),
        .req_valid(req_valid), .req_erase(req_erase), .req_addr(req_addr),
        .req_len(req_len), .req_ready(req_ready),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .cmd_req(cmd_req), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
        .cmd_tx_cnt(cmd_tx_cnt), .cmd_rx_cnt(cmd_rx_cnt),
        .cmd_tx_data(cmd_tx_data), .cmd_rx_data(cmd_rx_data),
        .cmd_done(cmd_done), .op_done(op_done), .op_error(op_error),
        .bytes_written(bytes_written)
    );

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;
    cmd_t expq[$];
    logic [7:0] sbuf [0:63];
    int   slen = 0;
    int   sidx = 0;
    int   poll_busy = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Byte stream source
    initial begin
        bit take = 0;
        forever begin
            @(negedge clk);
            if (take) sidx++;
            wr_valid = (sidx < slen);
            wr_data  = (sidx < 64) ? sbuf[sidx] : 8'h00;
            take = wr_valid && wr_ready;
        end
    end

    // Command engine model and scoreboard monitor
    initial begin
        int pend = 0;
        int polls_left = 0;
        logic [31:0] resp = '0;
        forever begin
            @(negedge clk);
            if (cmd_done) begin cmd_done = 0; cmd_rx_data = '0; end
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin cmd_done = 1; cmd_rx_data = resp; end
            end
            if (cmd_req) begin
                cmd_t got;
                got = '{op: cmd_opcode, addr: cmd_addr, tx: cmd_tx_cnt,
                        rx: cmd_rx_cnt, data: cmd_tx_data};
                if (expq.size() == 0) begin
                    chk(0, "R1/R2/R8", "unexpected command", 64'(got), 64'(0));
                end else begin
                    cmd_t e;
                    e = expq.pop_front();
                    // R3 R4 R5 R6 R7: command fields compared to the plan
                    chk(got == e, "R3-R7", $sformatf("command op %0h", e.op),
                        64'(got), 64'(e));
                end
                resp = '0;
                if (cmd_opcode == 8'h02 || cmd_opcode == 8'hD8) polls_left = poll_busy;
                if (cmd_opcode == 8'h05) begin
                    resp = (polls_left > 0) ? 32'h1 : 32'h0;
                    if (polls_left > 0) polls_left--;
                end
                pend = 2;
            end
        end
    end

    task automatic push_cmd(input logic [7:0] op, input logic [23:0] a,
                            input int tx, input int rx, input logic [31:0] d);
        cmd_t c;
        c = '{op: op, addr: a, tx: 4'(tx), rx: 4'(rx), data: d};
        expq.push_back(c);
    endtask

    task automatic push_polls(input int polls);
        for (int p = 0; p <= polls; p++) push_cmd(8'h05, 24'h0, 1, 1, 32'h0);
    endtask

    task automatic wait_done(input bit exp_err, input int exp_bytes, input string tag);
        int t = 0;
        while (!op_done && t < 4000) begin @(negedge clk); t++; end
        chk(op_done, tag, "op_done seen", 64'(op_done), 64'(1));
        chk(op_error == exp_err, (exp_err ? "R2" : tag), "op_error", 64'(op_error), 64'(exp_err));
        chk(bytes_written == 25'(exp_bytes), "R9", "bytes_written", 64'(bytes_written), 64'(exp_bytes));
        chk(expq.size() == 0, tag, "pending expected commands", 64'(expq.size()), 64'(0));
        @(negedge clk);
        chk(req_ready && !op_done, "R1", "back to idle", 64'({req_ready, op_done}), 64'(2'b10));
    endtask

    task automatic start_req(input bit erase, input logic [23:0] a, input int n);
        req_valid = 1; req_erase = erase; req_addr = a; req_len = 25'(n);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic do_write(input logic [7:0] sig, input logic [23:0] a, input int n,
                            input int polls, input bit refuse, input bit poke,
                            input string tag);
        int rem = n;
        int off = 0;
        logic [23:0] cur = a;
        dev_sig = sig; poll_busy = polls;
        for (int i = 0; i < 64; i++) sbuf[i] = 8'(a[7:0] + 8'(i * 7) + 8'h3);
        sidx = 0; slen = refuse ? 0 : n;
        if (!refuse) begin
            while (rem > 0) begin
                int room = 256 - int'(cur[7:0]);
                int c = rem;
                logic [31:0] d = '0;
                if (c > 4) c = 4;
                if (c > room) c = room;
                for (int j = 0; j < c; j++) d[j*8 +: 8] = sbuf[off + j];
                push_cmd(8'h06, 24'h0, 1, 0, 32'h0);
                push_cmd(8'h02, cur, c + 4, 0, d);
                push_polls(polls);
                cur = cur + 24'(c); off += c; rem -= c;
            end
        end
        @(negedge clk); @(negedge clk);
        start_req(1'b0, a, n);
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(!req_ready, "R1", "ready while busy", 64'(req_ready), 64'(0));
            req_valid = 1; req_erase = 1; req_addr = 24'h010000; req_len = 25'd1;
            @(negedge clk);
            req_valid = 0;
        end
        wait_done(refuse, refuse ? 0 : n, tag);
    endtask

    task automatic do_erase(input logic [7:0] sig, input logic [23:0] a, input int n,
                            input int polls, input bit refuse);
        dev_sig = sig; poll_busy = polls; slen = 0; sidx = 0;
        if (!refuse) begin
            push_cmd(8'h06, 24'h0, 1, 0, 32'h0);
            push_cmd(8'hD8, a, 4, 0, 32'h0);
            push_polls(polls);
        end
        @(negedge clk); @(negedge clk);
        start_req(1'b1, a, n);
        wait_done(refuse, 0, "R6");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready && !cmd_req && !wr_ready && !op_done && bytes_written == 0,
            "R1", "reset state", 64'({req_ready, cmd_req, wr_ready, op_done}), 64'(4'b1000));

        do_write(8'h13, 24'h000010, 4, 1, 0, 0, "R5");   // R5 full chunk
        do_write(8'h13, 24'h0000FE, 5, 0, 0, 0, "R3");   // R3 page split 2+3
        do_write(8'h13, 24'h002000, 9, 2, 0, 0, "R3");   // R3 4+4+1, R7 polls
        do_write(8'h13, 24'h000050, 0, 0, 0, 0, "R8");   // R8 zero length
        do_erase(8'h13, 24'h030000, 1, 3, 0);             // R6 R7 erase
        do_write(8'h13, 24'h0FFFFE, 3, 0, 1, 0, "R2");   // R2 overrun by one
        do_write(8'h13, 24'h0FFFFE, 2, 0, 0, 0, "R2");   // R2 exact end
        do_write(8'h17, 24'hFFFFFE, 2, 1, 0, 0, "R2");   // R2 16 MB top
        do_write(8'h12, 24'h000000, 1, 0, 1, 0, "R2");   // R2 bad signature low
        do_write(8'h18, 24'h000000, 1, 0, 1, 0, "R2");   // R2 bad signature high
        do_erase(8'h13, 24'h100000, 1, 0, 1);             // R2 erase past 1 MB
        do_erase(8'h14, 24'h100000, 1, 0, 0);             // R6 same on 2 MB
        do_write(8'h15, 24'h0003FD, 6, 2, 0, 1, "R1");   // R1 busy request ignored, R4 R10

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL R10 watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule